// File: doc/BRIEF.md
# Scanline Interrupt Down-Counter

This block raises an interrupt toward the CPU after a programmed number of video scanlines. An external circuit supplies a one-cycle pulse per scanline. Each pulse either refills an 8-bit counter from a latch or steps it down by one. The refill happens when the counter is already zero or a refill has been requested. If the count left by that pulse is zero and interrupts are enabled, the interrupt line rises.

The CPU drives the block through four write addresses. Two of them sit in one address window: one stores the latch value and the other requests a refill. The other two sit in a second window: one turns interrupts off and clears a pending request, and the other turns interrupts on. The interrupt is a held level. It stays high until the CPU writes the turn-off address or reset is applied. The data byte matters only for the latch write.

Top module: `scanline_irq_top`

## Requirements
- R1: After reset `irq` is low, and the counter, the latch and the enable are all zero. With interrupts left off, scanline pulses never raise `irq`. The first pulse after enabling reloads the zero latch, which leaves the count at zero and raises `irq`.
- R2: A write whose address, masked with 0xE001, equals 0xC000 stores `wr_data` into the latch. This includes aliases such as 0xD002.
- R3: A write whose masked address equals 0xC001 sets the refill flag. The next pulse then loads the latch, whatever the count is, and every pulse clears the flag.
- R4: A pulse that finds the count at zero loads the latch value current at that pulse.
- R5: A pulse that finds the count nonzero and the refill flag clear decrements the count by one. The count does not change between pulses.
- R6: If the count left by a pulse is zero and the enable is set, `irq` is high from the clock edge that sampled the pulse onward. With latch N>0 and a refill, `irq` rises on the (N+1)th pulse.
- R7: Once high, `irq` stays high through further pulses and idle cycles until a write whose masked address equals 0xE000. That write drops `irq` and clears the enable.
- R8: A write whose masked address equals 0xE001 sets the enable. While the enable is clear, a zero count raises nothing.
- R9: When a write and a pulse fall in the same cycle, the pulse uses the latch, flag and enable held before that edge. The write still takes effect: a refill request survives the concurrent pulse, and a disable keeps `irq` low.
- R10: Writes to any other masked address (for example 0x8000, 0x8001, 0xA000, 0xA001, 0x6000) change neither the count, the latch, the flags nor `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_tick | input | 1 | One-cycle pulse per scanline |
| wr_en | input | 1 | CPU write strobe, sampled on the clock edge |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| irq | output | 1 | Held interrupt request level |

## Verification
The hardest situation to reach is a CPU write landing in the same cycle as a scanline pulse. The outcome depends on which old and new register values the pulse sees, and the ports show it only indirectly, through how many later pulses pass before `irq` rises. The bench has a task that raises the write strobe and the pulse on the same falling edge. It then counts pulses to the next interrupt, so a refill request lost to the concurrent pulse gives a count one shorter than expected. A separate case lines up a disable write with the pulse that brings the count to zero, and checks that `irq` stays low.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
   typedef struct packed {
      logic latch_wr;
      logic reload_wr;
      logic disable_wr;
      logic enable_wr;
   } sirq_cmd_t;
endpackage

// File: rtl/sirq_decode.sv
module sirq_decode
   import sirq_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter logic [ADDR_W-1:0] MATCH_MASK = 16'hE001,
   parameter logic [ADDR_W-1:0] LATCH_ADDR = 16'hC000,
   parameter logic [ADDR_W-1:0] RELOAD_ADDR = 16'hC001,
   parameter logic [ADDR_W-1:0] DISABLE_ADDR = 16'hE000,
   parameter logic [ADDR_W-1:0] ENABLE_ADDR = 16'hE001
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   output sirq_cmd_t         cmd
);
   localparam int NCMD = 4;
   localparam logic [NCMD*ADDR_W-1:0] CODES =
      {LATCH_ADDR, RELOAD_ADDR, DISABLE_ADDR, ENABLE_ADDR};

   logic [ADDR_W-1:0] masked;
   logic [NCMD-1:0]   hit_vec;

   assign masked = wr_addr & MATCH_MASK;

   for (genvar i = 0; i < NCMD; i++) begin : g_match
      localparam logic [ADDR_W-1:0] CODE = CODES[i*ADDR_W +: ADDR_W];
      if ((CODE & ~MATCH_MASK) != '0) begin : g_bad_code
         $error("command address has bits outside the match mask");
      end
      for (genvar j = i + 1; j < NCMD; j++) begin : g_unique
         if (CODE == CODES[j*ADDR_W +: ADDR_W]) begin : g_dup
            $error("two command addresses decode alike");
         end
      end
      assign hit_vec[i] = wr_en && (masked == CODE);
   end

   assign cmd = sirq_cmd_t'(hit_vec);
endmodule

// File: rtl/sirq_counter.sv
module sirq_counter
   import sirq_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_tick,
   input  sirq_cmd_t        cmd,
   input  logic [CNT_W-1:0] load_val,
   output logic             zero_hit,
   output logic [CNT_W-1:0] count_q,
   output logic [CNT_W-1:0] latch_q,
   output logic             reload_q
);
   localparam logic [CNT_W-1:0] ZERO = '0;
   localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] count_nxt;
   logic             refill;

   assign refill    = (count_q == ZERO) || reload_q;
   assign count_nxt = refill ? latch_q : count_q - ONE;
   assign zero_hit  = line_tick && (count_nxt == ZERO);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q  <= ZERO;
         latch_q  <= ZERO;
         reload_q <= 1'b0;
      end else begin
         if (line_tick)
            count_q <= count_nxt;
         if (cmd.latch_wr)
            latch_q <= load_val;
         if (cmd.reload_wr)
            reload_q <= 1'b1;
         else if (line_tick)
            reload_q <= 1'b0;
      end
   end
endmodule

// File: rtl/sirq_flag.sv
module sirq_flag
   import sirq_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      zero_hit,
   input  sirq_cmd_t cmd,
   output logic      enable_q,
   output logic      irq_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable_q <= 1'b0;
         irq_q    <= 1'b0;
      end else if (cmd.disable_wr) begin
         enable_q <= 1'b0;
         irq_q    <= 1'b0;
      end else begin
         if (cmd.enable_wr)
            enable_q <= 1'b1;
         if (zero_hit && enable_q)
            irq_q <= 1'b1;
      end
   end
endmodule

// File: rtl/scanline_irq_top.sv
module scanline_irq_top
   import sirq_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter int CNT_W  = 8,
   parameter logic [ADDR_W-1:0] MATCH_MASK = 16'hE001,
   parameter logic [ADDR_W-1:0] LATCH_ADDR = 16'hC000,
   parameter logic [ADDR_W-1:0] RELOAD_ADDR = 16'hC001,
   parameter logic [ADDR_W-1:0] DISABLE_ADDR = 16'hE000,
   parameter logic [ADDR_W-1:0] ENABLE_ADDR = 16'hE001
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_tick,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              irq
);
   if (CNT_W < 1 || CNT_W != DATA_W) begin : g_bad_width
      $error("counter width must be nonzero and equal to the data width");
   end

   sirq_cmd_t        cmd;
   logic             zero_hit;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lat_q;
   logic             rld_q;
   logic             en_q;

   sirq_decode #(
      .ADDR_W(ADDR_W), .MATCH_MASK(MATCH_MASK), .LATCH_ADDR(LATCH_ADDR),
      .RELOAD_ADDR(RELOAD_ADDR), .DISABLE_ADDR(DISABLE_ADDR),
      .ENABLE_ADDR(ENABLE_ADDR)
   ) u_dec (
      .wr_en(wr_en), .wr_addr(wr_addr), .cmd(cmd)
   );

   sirq_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .cmd(cmd),
      .load_val(wr_data), .zero_hit(zero_hit), .count_q(cnt_q),
      .latch_q(lat_q), .reload_q(rld_q)
   );

   sirq_flag u_flag (
      .clk(clk), .rst_n(rst_n), .zero_hit(zero_hit), .cmd(cmd),
      .enable_q(en_q), .irq_q(irq)
   );
endmodule

// File: rtl/sirq_checker.sv
module sirq_checker
   import sirq_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             line_tick,
   input sirq_cmd_t        cmd,
   input logic [CNT_W-1:0] cnt_q,
   input logic [CNT_W-1:0] lat_q,
   input logic             rld_q,
   input logic             en_q,
   input logic             irq
);
   p_flag_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      line_tick && !cmd.reload_wr |=> !rld_q);
   p_flag_refill_r3: assert property (@(posedge clk) disable iff (!rst_n)
      line_tick && rld_q |=> cnt_q == $past(lat_q));
   p_zero_refill_r4: assert property (@(posedge clk) disable iff (!rst_n)
      line_tick && cnt_q == '0 |=> cnt_q == $past(lat_q));
   p_step_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
      line_tick && cnt_q != '0 && !rld_q |=> cnt_q == $past(cnt_q) - 1'b1);
   p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !line_tick |=> $stable(cnt_q));
   p_no_rise_without_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !irq && !line_tick |=> !irq);
   p_level_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq && !cmd.disable_wr |=> irq);
   p_disable_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cmd.disable_wr |=> !irq && !en_q);
   p_enable_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cmd.enable_wr && !cmd.disable_wr |=> en_q);
endmodule

bind scanline_irq_top sirq_checker #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .cmd(cmd),
   .cnt_q(cnt_q), .lat_q(lat_q), .rld_q(rld_q), .en_q(en_q), .irq(irq)
);

// File: tb/scanline_irq_top_test.sv
`timescale 1ns/1ps
module scanline_irq_top_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        line_tick = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        irq;
   int          errors = 0;
   int          checks = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   scanline_irq_top uut (
      .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .irq(irq)
   );

   task automatic check(string req, int actual, int expected);
      checks++;
      if (actual != expected) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
      end
   endtask

   task automatic cpu_write(logic [15:0] a, logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse();
      @(negedge clk);
      line_tick = 1'b1;
      @(negedge clk);
      line_tick = 1'b0;
   endtask

   task automatic write_with_pulse(logic [15:0] a, logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d; line_tick = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; line_tick = 1'b0;
   endtask

   // pulses until irq is seen; returns the pulse count, or 99 if none
   task automatic pulses_to_irq(output int n);
      n = 99;
      for (int i = 1; i <= 40; i++) begin
         pulse();
         if (irq) begin n = i; break; end
      end
   endtask

   task automatic arm(logic [7:0] n, bit en);
      cpu_write(16'hC000, n);
      cpu_write(16'hC001, 8'h00);
      cpu_write(16'hE000, 8'h00);
      if (en) cpu_write(16'hE001, 8'h00);
   endtask

   task automatic t_reset();
      int n;
      check("R1 irq low after reset", irq, 0);
      for (int i = 0; i < 5; i++) pulse();
      check("R1 no irq while disabled", irq, 0);
      cpu_write(16'hE001, 8'h00);
      pulse();
      check("R1 zero latch and count give irq at once", irq, 1);
      cpu_write(16'hE000, 8'h00);
      check("R7 disable drops irq", irq, 0);
   endtask

   task automatic t_count();
      int n;
      arm(8'd3, 1'b1);
      pulses_to_irq(n);
      check("R6 latch 3 irq on pulse 4 (R2 R3 R5)", n, 4);
      repeat (4) @(negedge clk);
      check("R7 irq held while idle", irq, 1);
      pulse();
      check("R7 irq held through pulses", irq, 1);
      cpu_write(16'hE000, 8'h00);
      check("R7 irq cleared by disable", irq, 0);
      arm(8'd0, 1'b1);
      pulses_to_irq(n);
      check("R6 latch 0 irq on first pulse", n, 1);
   endtask

   task automatic t_zero_reload();
      int n;
      arm(8'd2, 1'b1);
      pulses_to_irq(n);
      check("R6 latch 2 irq on pulse 3", n, 3);
      cpu_write(16'hE000, 8'h00);
      cpu_write(16'hE001, 8'h00);
      cpu_write(16'hD002, 8'd5);
      pulses_to_irq(n);
      check("R4 zero count reloads new latch 5 (R2 alias)", n, 6);
   endtask

   task automatic t_reload_mid();
      int n;
      arm(8'd5, 1'b1);
      pulse(); pulse();
      cpu_write(16'hC000, 8'd1);
      cpu_write(16'hC001, 8'h00);
      pulses_to_irq(n);
      check("R3 reload request mid count", n, 2);
   endtask

   task automatic t_enable();
      int n;
      arm(8'd2, 1'b0);
      for (int i = 0; i < 3; i++) pulse();
      check("R8 no irq at zero while disabled", irq, 0);
      cpu_write(16'hE001, 8'h00);
      pulses_to_irq(n);
      check("R8 after enable, zero refills then counts", n, 3);
   endtask

   task automatic t_ignored();
      int n;
      arm(8'd3, 1'b1);
      pulse();
      cpu_write(16'h8000, 8'd9);
      cpu_write(16'h8001, 8'd9);
      cpu_write(16'hA000, 8'd9);
      cpu_write(16'hA001, 8'd9);
      cpu_write(16'h6000, 8'd9);
      check("R10 foreign writes leave irq low", irq, 0);
      pulses_to_irq(n);
      check("R10 count unchanged by foreign writes", n, 3);
   endtask

   task automatic t_same_cycle();
      int n;
      arm(8'd3, 1'b1);
      pulse();
      write_with_pulse(16'hC000, 8'd7);
      pulses_to_irq(n);
      check("R9 concurrent latch write, pulse uses old latch", n, 2);
      cpu_write(16'hE000, 8'h00);
      cpu_write(16'hE001, 8'h00);
      write_with_pulse(16'hC001, 8'h00);
      check("R9 reload pulse from zero to 7 gives no irq", irq, 0);
      pulses_to_irq(n);
      check("R9 reload request survives concurrent pulse", n, 8);
      arm(8'd1, 1'b1);
      pulse();
      write_with_pulse(16'hE000, 8'h00);
      check("R9 disable beats concurrent zero pulse", irq, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_count();
      t_zero_reload();
      t_reload_mid();
      t_enable();
      t_ignored();
      t_same_cycle();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule